// File: doc/BRIEF.md
# LED String Fault Supervisor

This block watches eight LED strings and the boost converter that feeds them, decides which strings stay in regulation and when the converter must be latched off, and keeps a record of every fault class for software. Comparator outputs arrive as level flags: one short flag and one low-voltage (open) flag for each string, plus single over-voltage, over-current and over-temperature flags. A one-cycle tick marks every switching period, and a level enable input gates supervision.

A string whose short flag stays high long enough is removed from regulation and stays removed until the enable input falls. If removals leave no enabled string in regulation, or the over-current flag holds for several consecutive switching periods, the converter shutdown output latches. Five sticky fault bits and a fixed identity byte sit in a 16-bit read word. A read strobe clears the sticky bits, and an event that lands in the same cycle as the read stays recorded.

Top module: `led_fault_sup`

## Requirements
- R1: A string whose mask bit is 1 and whose short flag is high at SHORT_TICKS consecutive switching ticks is cleared from `activeMask` on the clock edge that samples the last of those ticks. Status bit 0 (short) sets on the same edge. Cycles without a tick neither advance nor reset the count.
- R2: A clock edge that samples the short flag low restarts that string's count from zero, so a full SHORT_TICKS run is needed again.
- R3: A removed string stays out of `activeMask` while `enable` stays high, even after its short flag drops.
- R4: When strings have been removed and no string with mask bit 1 remains in `activeMask`, `convOff` goes high one clock edge later and stays high while `enable` stays high.
- R5: The over-current flag sampled high at OC_CYCLES consecutive ticks sets `convOff` and status bit 3 on the edge of the last such tick. A tick with the flag low restarts the run.
- R6: `rdData` holds the identity byte 0x11 in bits 15:8 and zeros in bits 7:5. Bit 4 records over-temperature, bit 3 the over-current latch-off, bit 2 over-voltage, bit 1 an open flag on a string in `activeMask`, and bit 0 a short removal. Flag events are recorded only while `enable` is high.
- R7: Status bits are sticky. `rdData` shows them during a cycle with `rdEn` high, and they read as zero from the next edge on, unless set again.
- R8: A fault event in the same cycle as `rdEn` leaves its bit set after the clear.
- R9: A string whose `chanEnMask` bit is 0 is never in `activeMask`, is never timed or removed, and its open flag sets no status bit.
- R10: A falling edge of `enable` returns `activeMask` to `chanEnMask` and clears `convOff` and the over-current latch on the next edge, leaving status bits unchanged. While `enable` is low no string is removed.
- R11: After reset `activeMask` equals `chanEnMask`, `convOff` is 0 and `rdData` is 0x1100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Supervision enable; a falling edge restarts the strings and the converter |
| swTick | input | 1 | One-cycle pulse per switching period |
| chanEnMask | input | 8 | Strings in use, bit i for string i |
| shortFlag | input | 8 | Per-string short comparator flags |
| openFlag | input | 8 | Per-string low-voltage (open) flags |
| ovFlag | input | 1 | Output over-voltage flag |
| ocFlag | input | 1 | Low-side over-current flag |
| otFlag | input | 1 | Die over-temperature flag |
| rdEn | input | 1 | Status read strobe; clears sticky bits after this cycle |
| rdData | output | 16 | Identity byte and sticky status bits |
| activeMask | output | 8 | Strings currently kept in regulation |
| convOff | output | 1 | Latched converter shutdown |

## Verification
Every result here moves one clock edge after the cycle that causes it: a removal and its short bit on the edge sampling the final counted tick, an over-current latch-off on the edge of the last qualifying tick, and a status clear on the edge after the read. `convOff` from an all-removed condition comes one edge later still, because it is built from the registered removal mask. The bench drives inputs on falling clock edges and samples on the falling edge after the edge where a result is due. Where the timing is the point, it checks one edge before as well, so an off-by-one count shows up as a mismatch.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;

  localparam int STAT_W   = 5;
  localparam int ST_SHORT = 0;
  localparam int ST_OPEN  = 1;
  localparam int ST_OVP   = 2;
  localparam int ST_OCP   = 3;
  localparam int ST_OTP   = 4;
  localparam logic [7:0] DEV_ID = 8'h11;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;    // enable falling edge seen this cycle
    logic supervise;  // supervision active (enable high)
    logic clrStatus;  // read strobe: clear sticky bits at this edge
    logic ocTrip;     // over-current latch-off fires at this edge
  } sup_ctl_t;

endpackage

// File: rtl/led_short_timer.sv
module led_short_timer #(
  parameter int LIMIT = 8280
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic supervise,
  input  logic chEn,
  input  logic shortIn,
  input  logic tick,
  output logic removed,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic armed;

  assign armed = supervise & chEn & ~removed & shortIn;
  assign fire  = armed & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      removed <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      removed <= 1'b0;
    end else if (!armed) begin
      cnt <= '0;
    end else if (tick) begin
      if (fire) begin
        removed <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_fault_datapath.sv
module led_fault_datapath
  import led_fault_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SHORT_TICKS = 8280
) (
  input  logic              clk,
  input  logic              rstN,
  input  sup_ctl_t          ctl,
  input  logic              swTick,
  input  logic [NUM_CH-1:0] chanEnMask,
  input  logic [NUM_CH-1:0] shortFlag,
  input  logic [NUM_CH-1:0] openFlag,
  input  logic              ovFlag,
  input  logic              otFlag,
  output logic [NUM_CH-1:0] activeMask,
  output logic              allRemoved,
  output logic [STAT_W-1:0] statusBits
);
  logic [NUM_CH-1:0] removedMask;
  logic [NUM_CH-1:0] fireVec;
  logic [STAT_W-1:0] setEv;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    led_short_timer #(.LIMIT(SHORT_TICKS)) u_timer (
      .clk      (clk),
      .rstN     (rstN),
      .restart  (ctl.restart),
      .supervise(ctl.supervise),
      .chEn     (chanEnMask[i]),
      .shortIn  (shortFlag[i]),
      .tick     (swTick),
      .removed  (removedMask[i]),
      .fire     (fireVec[i])
    );
  end

  assign activeMask = chanEnMask & ~removedMask;
  assign allRemoved = (|(removedMask & chanEnMask)) & ~(|activeMask);

  always_comb begin
    setEv           = '0;
    setEv[ST_SHORT] = |fireVec;
    setEv[ST_OPEN]  = ctl.supervise & (|(openFlag & activeMask));
    setEv[ST_OVP]   = ctl.supervise & ovFlag;
    setEv[ST_OCP]   = ctl.ocTrip;
    setEv[ST_OTP]   = ctl.supervise & otFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusBits <= '0;
    else       statusBits <= (ctl.clrStatus ? '0 : statusBits) | setEv;
  end
endmodule

// File: rtl/led_fault_ctrl.sv
module led_fault_ctrl
  import led_fault_pkg::*;
#(
  parameter int OC_CYCLES = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     swTick,
  input  logic     ocFlag,
  input  logic     rdEn,
  input  logic     allRemoved,
  output sup_ctl_t ctl,
  output logic     convOff
);
  localparam int OW = $clog2(OC_CYCLES + 1);
  localparam logic [OW-1:0] OC_LAST = OW'(OC_CYCLES - 1);

  logic          enPrev;
  logic          ocLatched;
  logic [OW-1:0] ocCnt;
  logic          restart;
  logic          ocTrip;
  logic          ocSample;

  assign restart  = enPrev & ~enable;
  assign ocSample = enable & swTick & ~ocLatched;
  assign ocTrip   = ocSample & ocFlag & (ocCnt == OC_LAST);

  always_comb begin
    ctl           = '0;
    ctl.restart   = restart;
    ctl.supervise = enable;
    ctl.clrStatus = rdEn;
    ctl.ocTrip    = ocTrip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocCnt     <= '0;
      ocLatched <= 1'b0;
      convOff   <= 1'b0;
    end else if (restart) begin
      ocCnt     <= '0;
      ocLatched <= 1'b0;
      convOff   <= 1'b0;
    end else begin
      if (ocSample) begin
        if (!ocFlag)     ocCnt <= '0;
        else if (ocTrip) begin
          ocCnt     <= '0;
          ocLatched <= 1'b1;
        end else         ocCnt <= ocCnt + 1'b1;
      end
      convOff <= convOff | ocTrip | (enable & allRemoved);
    end
  end
endmodule

// File: rtl/led_fault_sup.sv
module led_fault_sup
  import led_fault_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SHORT_TICKS = 8280,
  parameter int OC_CYCLES   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              swTick,
  input  logic [NUM_CH-1:0] chanEnMask,
  input  logic [NUM_CH-1:0] shortFlag,
  input  logic [NUM_CH-1:0] openFlag,
  input  logic              ovFlag,
  input  logic              ocFlag,
  input  logic              otFlag,
  input  logic              rdEn,
  output logic [15:0]       rdData,
  output logic [NUM_CH-1:0] activeMask,
  output logic              convOff
);
  localparam int PAD_W = 8 - STAT_W;

  sup_ctl_t          ctl;
  logic              allRemoved;
  logic [STAT_W-1:0] statusBits;

  led_fault_ctrl #(.OC_CYCLES(OC_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .swTick    (swTick),
    .ocFlag    (ocFlag),
    .rdEn      (rdEn),
    .allRemoved(allRemoved),
    .ctl       (ctl),
    .convOff   (convOff)
  );

  led_fault_datapath #(.NUM_CH(NUM_CH), .SHORT_TICKS(SHORT_TICKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .swTick    (swTick),
    .chanEnMask(chanEnMask),
    .shortFlag (shortFlag),
    .openFlag  (openFlag),
    .ovFlag    (ovFlag),
    .otFlag    (otFlag),
    .activeMask(activeMask),
    .allRemoved(allRemoved),
    .statusBits(statusBits)
  );

  assign rdData = {DEV_ID, {PAD_W{1'b0}}, statusBits};
endmodule

// File: rtl/led_fault_sup_chk.sv
module led_fault_sup_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [NUM_CH-1:0] chanEnMask,
  input logic [NUM_CH-1:0] activeMask,
  input logic              convOff,
  input logic [15:0]       rdData
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3: no string comes back while enable stayed high and the mask held
  a_r3_no_revive: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(enable) && $stable(chanEnMask))
      |-> ((activeMask & ~$past(activeMask)) == '0));

  // R1: a removal is recorded in the short bit on the same edge
  a_r1_removal_logged: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(enable) && $stable(chanEnMask) && (activeMask != $past(activeMask)))
      |-> rdData[0]);

  // R4: shutdown holds while enable stays high
  a_r4_off_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && convOff && enable) |=> convOff);

  // R5: the over-current bit only appears together with shutdown
  a_r5_ocp_with_off: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(rdData[3])) |-> convOff);

  // R10: enable falling edge restores strings and releases shutdown
  a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $fell(enable)) |=> (!convOff && (activeMask == chanEnMask)));
endmodule

bind led_fault_sup led_fault_sup_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .chanEnMask(chanEnMask),
  .activeMask(activeMask),
  .convOff   (convOff),
  .rdData    (rdData)
);

// File: tb/led_fault_sup_tb.sv
`timescale 1ns/1ps
module led_fault_sup_tb;
  localparam int LIM = 12;
  localparam int OCN = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        swTick = 1'b1;
  logic [7:0]  chanEnMask = 8'hFF;
  logic [7:0]  shortFlag = '0;
  logic [7:0]  openFlag = '0;
  logic        ovFlag = 1'b0;
  logic        ocFlag = 1'b0;
  logic        otFlag = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [7:0]  activeMask;
  logic        convOff;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  led_fault_sup #(.NUM_CH(8), .SHORT_TICKS(LIM), .OC_CYCLES(OCN)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .swTick(swTick),
    .chanEnMask(chanEnMask), .shortFlag(shortFlag), .openFlag(openFlag),
    .ovFlag(ovFlag), .ocFlag(ocFlag), .otFlag(otFlag), .rdEn(rdEn),
    .rdData(rdData), .activeMask(activeMask), .convOff(convOff)
  );

  // vector: {mask[22:15], open[14:7], ov[6], ot[5], expStatus[4:0]}
  localparam logic [22:0] VEC [6] = '{
    {8'hFF, 8'h01, 1'b0, 1'b0, 5'b00010},
    {8'hFE, 8'h01, 1'b0, 1'b0, 5'b00000},
    {8'hFF, 8'h00, 1'b1, 1'b0, 5'b00100},
    {8'hFF, 8'h00, 1'b0, 1'b1, 5'b10000},
    {8'h0F, 8'hF0, 1'b0, 1'b0, 5'b00000},
    {8'h0F, 8'h08, 1'b1, 1'b1, 5'b10110}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readClear();
    rdEn = 1'b1;
    cyc(1);
    rdEn = 1'b0;
  endtask

  task automatic toggleEnable();
    enable = 1'b0;
    cyc(1);
    enable = 1'b1;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R11 reset state
    chk("R11 activeMask", 32'(activeMask), 32'hFF);
    chk("R11 convOff", 32'(convOff), 32'h0);
    chk("R11 rdData", 32'(rdData), 32'h1100);
    enable = 1'b1;
    cyc(1);

    // table of status stimulus (R6, R7, R9)
    for (int k = 0; k < 6; k++) begin
      chanEnMask = VEC[k][22:15];
      openFlag   = VEC[k][14:7];
      ovFlag     = VEC[k][6];
      otFlag     = VEC[k][5];
      cyc(1);
      openFlag = '0; ovFlag = 1'b0; otFlag = 1'b0;
      chk($sformatf("R6/R9 vector %0d status", k), 32'(rdData), {16'h0, 8'h11, 3'b0, VEC[k][4:0]});
      chk($sformatf("R9 vector %0d activeMask", k), 32'(activeMask), 32'(VEC[k][22:15]));
      readClear();
      chk($sformatf("R7 vector %0d cleared", k), 32'(rdData[4:0]), 32'h0);
    end
    chanEnMask = 8'hFF;
    cyc(1);

    // R1: short on string 2, exact tick count; no-tick cycles do not count
    shortFlag[2] = 1'b1;
    cyc(3);
    swTick = 1'b0;
    cyc(20);
    swTick = 1'b1;
    chk("R1 hold without ticks", 32'(activeMask), 32'hFF);
    cyc(LIM - 4);
    chk("R1 one tick early", 32'(activeMask), 32'hFF);
    cyc(1);
    chk("R1 removed", 32'(activeMask), 32'hFB);
    chk("R1 short bit", 32'(rdData[0]), 32'h1);

    // R3: removal persists after the flag drops
    shortFlag[2] = 1'b0;
    cyc(LIM + 3);
    chk("R3 stays removed", 32'(activeMask), 32'hFB);

    // R7 + R8: read with a simultaneous over-voltage event
    rdEn = 1'b1; ovFlag = 1'b1;
    cyc(1);
    rdEn = 1'b0; ovFlag = 1'b0;
    chk("R8 event kept over read", 32'(rdData[4:0]), 32'h04);
    readClear();
    chk("R7 cleared after read", 32'(rdData[4:0]), 32'h0);

    // R2: a one-cycle drop restarts the count on string 3
    shortFlag[3] = 1'b1;
    cyc(LIM - 1);
    shortFlag[3] = 1'b0;
    cyc(1);
    shortFlag[3] = 1'b1;
    cyc(LIM - 1);
    chk("R2 count restarted", 32'(activeMask), 32'hFB);
    cyc(1);
    chk("R2 removed after full run", 32'(activeMask), 32'hF3);
    shortFlag[3] = 1'b0;

    // R4: remove the last two supervised strings under mask 0x0F
    chanEnMask = 8'h0F;
    shortFlag[1:0] = 2'b11;
    cyc(LIM);
    chk("R4 all removed", 32'(activeMask), 32'h00);
    chk("R4 off not yet", 32'(convOff), 32'h0);
    cyc(1);
    chk("R4 converter off", 32'(convOff), 32'h1);
    shortFlag = '0;
    cyc(5);
    chk("R4 off held", 32'(convOff), 32'h1);

    // R10: enable fall restarts, status kept, no removal while low
    enable = 1'b0;
    shortFlag[0] = 1'b1;
    cyc(1);
    chk("R10 strings back", 32'(activeMask), 32'h0F);
    chk("R10 off released", 32'(convOff), 32'h0);
    chk("R10 status kept", 32'(rdData[0]), 32'h1);
    cyc(LIM + 4);
    chk("R10 no removal while disabled", 32'(activeMask), 32'h0F);
    shortFlag = '0;
    enable = 1'b1;
    cyc(1);
    readClear();

    // R5: over-current run broken once, then a full run
    chanEnMask = 8'hFF;
    ocFlag = 1'b1;
    cyc(OCN - 1);
    ocFlag = 1'b0;
    cyc(1);
    ocFlag = 1'b1;
    cyc(OCN - 1);
    chk("R5 broken run no trip", 32'(convOff), 32'h0);
    chk("R5 no ocp bit yet", 32'(rdData[3]), 32'h0);
    cyc(1);
    chk("R5 trip", 32'(convOff), 32'h1);
    chk("R5 ocp bit", 32'(rdData[3]), 32'h1);
    ocFlag = 1'b0;
    toggleEnable();
    chk("R10 oc latch released", 32'(convOff), 32'h0);
    chk("R6 id byte", 32'(rdData[15:5]), 32'h088);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule